// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `WIDTH` bits (default 4, at least 2) and returns the full `2*WIDTH`-bit product. It uses a single `WIDTH`-bit ripple adder and takes `WIDTH` clock cycles per product. Three registers hold the working state. `M` holds the multiplicand. `A` is the accumulator and forms the upper half of the running product. `Q` starts with the multiplier and fills with low product bits as the operation proceeds.

Each step adds either `M` or zero to `A`, depending on the least significant bit of `Q`. The adder's carry-out, the sum and `Q` then shift right together by one place. The carry becomes the new top bit of `A`, and the retired multiplier bit drops out of the bottom of `Q`.

The `start` pin behaves like a valid strobe, and the `busy` pin acts as its inverted ready. A request is accepted only in a cycle where `busy` is low. A request raised while `busy` is high is dropped, not queued. The caller must therefore hold `start` until it sees `busy` rise. The product is not back-pressured: it stays on `product` until the next accepted request.

Top module: `shiftadd_mult`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `busy` = 0, `done` = 0 and `product` = 0.
- R2: When `start` = 1 and `busy` = 0 at a rising edge, the operands are captured. After that edge, `busy` = 1 and `product` = {WIDTH zeros, multiplier}, which means the accumulator is cleared.
- R3: Suppose a request is accepted at edge k. Then after edge k+WIDTH, `product` = multiplicand × multiplier, `busy` = 0 and `done` = 1.
- R4: `done` is high for exactly one cycle per operation and is never high together with `busy`.
- R5: A `start` raised while `busy` = 1 is ignored. Neither the running result nor its timing changes.
- R6: While `busy` = 0 and `start` = 0, `product` holds its value.
- R7: Suppose a request with multiplicand a and multiplier b is accepted at edge k. After edge k+i, for 1 ≤ i < WIDTH, `product` = ((a × (b mod 2^i)) << (WIDTH−i)) + (b >> i). This is the right-shifted partial sum, followed by the multiplier bits not yet used.
- R8: Changes on `mcand` or `mplier` after the accepting edge have no effect on the operation in progress.
- R9: The adder carry-out enters the top bit of the accumulator on every step. All-ones operands therefore give (2^WIDTH−1)^2 with no lost bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when `busy` is low |
| mcand | input | WIDTH | Multiplicand operand |
| mplier | input | WIDTH | Multiplier operand |
| product | output | 2*WIDTH | Running product, shown as {A, Q} |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
Because `product` shows {A, Q} on every cycle, a wrong add decision, a lost carry or a misrouted shift bit appears on the ports within one clock of the faulty step. The fault shows up as a mismatch against the closed-form partial product of R7. It does not first hide until the final result. A counter fault shows as `done` arriving one cycle early or late against the fixed WIDTH-step latency. A missing busy guard shows as a reload of {0, multiplier} in the middle of an operation. Both are checked on every cycle of every operation, including operations where the operands and `start` are disturbed while busy.

// File: rtl/shiftadd_pkg.sv
package shiftadd_pkg;

  // Command from the sequencer to the register datapath.
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // one add-then-shift step
  } dp_cmd_t;

  // Counter width for a count of n steps (at least one bit).
  function automatic int cnt_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/shiftadd_rca.sv
module shiftadd_rca #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_i,
  input  logic [WIDTH-1:0] y_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;

  // One full-adder cell per bit; carries ripple upward.
  for (genvar g = 0; g < WIDTH; g++) begin : g_cell
    logic half;
    assign half         = x_i[g] ^ y_i[g];
    assign sum_o[g]     = half ^ carry[g];
    assign carry[g + 1] = (x_i[g] & y_i[g]) | (carry[g] & half);
  end

  assign cout_o = carry[WIDTH];

endmodule

// File: rtl/shiftadd_datapath.sv
module shiftadd_datapath
  import shiftadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dp_cmd_t            cmd_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] product_o
);

  logic [WIDTH-1:0] m_q;
  logic [WIDTH-1:0] a_q;
  logic [WIDTH-1:0] q_q;
  logic [WIDTH-1:0] addend;
  logic [WIDTH-1:0] sum;
  logic             cout;

  // Operand select: multiplicand or zero, steered by the retiring bit.
  assign addend = q_q[0] ? m_q : '0;

  shiftadd_rca #(.WIDTH(WIDTH)) u_rca (
    .x_i    (a_q),
    .y_i    (addend),
    .cin_i  (1'b0),
    .sum_o  (sum),
    .cout_o (cout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q <= '0;
      a_q <= '0;
      q_q <= '0;
    end else if (cmd_i.load) begin
      m_q <= mcand_i;
      a_q <= '0;
      q_q <= mplier_i;
    end else if (cmd_i.step) begin
      // {carry, sum, Q} moves right one place; Q's old LSB is dropped.
      {a_q, q_q} <= {cout, sum, q_q[WIDTH-1:1]};
    end
  end

  assign product_o = {a_q, q_q};

  // R6: without a command the running product does not move.
  a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_i.load && !cmd_i.step) |=> $stable(product_o));

  // R8: the multiplicand register changes only on a load.
  a_r8_mcand_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_i.load |=> $stable(m_q));

endmodule

// File: rtl/shiftadd_ctrl.sv
module shiftadd_ctrl
  import shiftadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  output dp_cmd_t cmd_o,
  output logic    busy_o,
  output logic    done_o
);

  localparam int             CW   = cnt_bits(WIDTH);
  localparam logic [CW-1:0]  LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic          accept;

  assign accept     = start_i && !busy_q;
  assign cmd_o.load = accept;
  assign cmd_o.step = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R4: done is a single-cycle pulse.
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R4: done and busy are exclusive.
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && busy_q));

  // R3: done appears only as busy falls.
  a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $fell(busy_q));

  // R3: the step counter stays inside the WIDTH-step window.
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5: a start while busy does not restart the count.
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != LAST) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/shiftadd_mult.sv
module shiftadd_mult
  import shiftadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic [2*WIDTH-1:0] product,
  output logic               busy,
  output logic               done
);

  dp_cmd_t cmd;

  shiftadd_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .cmd_o   (cmd),
    .busy_o  (busy),
    .done_o  (done)
  );

  shiftadd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd),
    .mcand_i   (mcand),
    .mplier_i  (mplier),
    .product_o (product)
  );

  // R2: an accepted request clears A and shows the multiplier in Q.
  a_r2_load_view: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && product == {{WIDTH{1'b0}}, $past(mplier)}));

  // R6: idle without a request keeps the product steady.
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

// File: tb/shiftadd_mult_bench.sv
module shiftadd_mult_bench;

  localparam int W = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   mcand;
  logic [W-1:0]   mplier;
  logic [2*W-1:0] product;
  logic           busy;
  logic           done;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;   // 250 MHz

  shiftadd_mult #(.WIDTH(W)) u_shiftadd_mult (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product),
    .busy    (busy),
    .done    (done)
  );

  function automatic logic [2*W-1:0] exp_final(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p[2*W-1:0];
  endfunction

  // Partial view after i steps: (a * low i bits of b) << (W-i), plus b >> i.
  function automatic logic [2*W-1:0] exp_step(input logic [W-1:0] a, input logic [W-1:0] b,
                                               input int i);
    logic [63:0] lowb;
    logic [63:0] p;
    lowb = 64'(b) & ((64'd1 << i) - 64'd1);
    p = ((64'(a) * lowb) << (W - i)) + (64'(b) >> i);
    return p[2*W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    logic [2*W-1:0] fin;
    fin = exp_final(a, b);
    @(negedge clk);
    start  = 1'b1;
    mcand  = a;
    mplier = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after accept", 64'(busy), 64'd1);
    chk(product == {{W{1'b0}}, b}, "R2 load view", 64'(product), 64'(b));
    for (int i = 1; i <= W; i++) begin
      if (disturb) begin
        mcand  = W'($urandom);
        mplier = W'($urandom);
        start  = 1'($urandom);     // R5: ignored while busy
      end
      @(negedge clk);
      start = 1'b0;
      if (i < W) begin
        chk(product == exp_step(a, b, i), "R7 partial product", 64'(product),
            64'(exp_step(a, b, i)));
        chk(busy == 1'b1 && done == 1'b0, "R3 still busy", 64'({busy, done}), 64'b10);
      end else begin
        chk(product == fin, disturb ? "R3 R5 R8 final product" : "R3 final product",
            64'(product), 64'(fin));
        chk(busy == 1'b0 && done == 1'b1, "R3 done timing", 64'({busy, done}), 64'b01);
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R4 single done pulse", 64'(done), 64'd0);
    chk(product == fin, "R6 idle hold", 64'(product), 64'(fin));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n  = 1'b0;
    start  = 1'b0;
    mcand  = '0;
    mplier = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state",
        64'({busy, done, product}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after release",
        64'({busy, done, product}), 64'd0);

    // Directed corners.
    run_op(4'b1101, 4'b1011, 1'b0);          // 13 x 11 = 143
    run_op('1, '1, 1'b0);                    // R9 carry into top of A
    run_op('1, '1, 1'b1);                    // R9 with disturbance
    run_op('0, '1, 1'b0);
    run_op('1, '0, 1'b1);

    // Exhaustive sweep; some operations disturbed while busy.
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        run_op(W'(a), W'(b), bit'((a + b) % 3 == 0));
      end
    end

    // Random operations with random disturbance.
    for (int k = 0; k < 100; k++) begin
      run_op(W'($urandom), W'($urandom), 1'($urandom));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule